// File: doc/BRIEF.md
# FEAC Codeword Repeating Transmitter

This block drives the one-bit far-end alarm and control channel that a DS3 framer carries once per M-frame. Software writes a six-bit message together with an enable flag. The block turns the message into a sixteen-bit codeword by adding an eight-bit all-ones flag and two framing zeros. It then sends the codeword one bit per slot strobe from the framer, least significant bit first. The strobe marks the channel bit position in each M-frame.

Each newly written message is sent ten times. The block then raises an interrupt asking for the next message, and it keeps repeating the last codeword until that message arrives. When the block is disabled or has no message, it sends the flag pattern. While the framer reports AIS, or is not running in internal DS3 mode, the channel is held at one and the block's progress is frozen.

Top module: `feac_tx`

## Requirements
- R1: After reset, `tx_bit` is 1 and `irq` is 0. Until a message is written with the enable set, every channel bit is 1.
- R2: The codeword bits are numbered 0 to 15. Bits 7..0 are all 1 and bit 8 is 0. Bits 11..9 carry `wr_msg[5:3]`, bits 14..12 carry `wr_msg[2:0]`, and bit 15 is 0.
- R3: `tx_bit` presents codeword bit 0 first. The block moves to the next bit on each cycle where `slot_stb` is high and neither hold condition (R9) applies.
- R4: After a message is loaded with `wr_enable`=1, its codeword is sent completely exactly 10 times. `irq` rises on the strobe that completes the tenth copy, and not before.
- R5: `irq` stays high until the next cycle with `wr_en` high. That write clears it.
- R6: A write never cuts the codeword in flight. The new codeword starts at the next codeword boundary and begins a fresh run of 10.
- R7: After the tenth copy, the block keeps sending the same codeword, with `irq` high, until the next write.
- R8: A write with `wr_enable`=0 clears `irq`. After the current codeword finishes, the channel sends only 1s, and `irq` stays low until a later write with the enable set.
- R9: While `ais_active`=1 or `ds3_mode`=0, `tx_bit` is 1 and strobes do not advance the block. When the condition clears, the interrupted codeword restarts at bit 0, and the partial copy does not count toward the 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Message register write strobe |
| wr_msg | input | 6 | Message field, loaded as mmmxxx |
| wr_enable | input | 1 | Enable value written with the message |
| slot_stb | input | 1 | Channel bit slot strobe from the framer |
| ds3_mode | input | 1 | Framer runs in internal DS3 mode |
| ais_active | input | 1 | Framer is sending AIS |
| tx_bit | output | 1 | Channel bit for the current slot |
| irq | output | 1 | Request for the next message |

## Verification
Every one of the 64 message values is sent through a full run and compared word by word against a codeword built from the bit layout. These runs separate errors in field placement from errors in the repeat count, because `irq` is checked both after the ninth copy and after the tenth. A write in the middle of a codeword shows whether the block finishes the word in flight. Holds from AIS and from loss of DS3 mode, placed partway through a word, show whether the partial copy is restarted and left uncounted. A disabling write followed by a re-enabling write separates flag-only idle from a stalled message.

// File: rtl/feac_tx.sv
module feac_tx #(
  parameter int REPEATS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_msg,
  input  logic       wr_enable,
  input  logic       slot_stb,
  input  logic       ds3_mode,
  input  logic       ais_active,
  output logic       tx_bit,
  output logic       irq
);
  localparam int CW_W  = 16;
  localparam int IDX_W = $clog2(CW_W);
  localparam int CNT_W = $clog2(REPEATS + 1);
  localparam logic [CW_W-1:0] FLAG_WORD = '1;

  logic [5:0]       msg_q;
  logic             en_q, pend_q, live_q, irq_q;
  logic [CW_W-1:0]  word_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  wire hold = ais_active || !ds3_mode;
  wire last = (idx_q == IDX_W'(CW_W - 1));
  wire [CW_W-1:0] next_word = {1'b0, msg_q[2:0], msg_q[5:3], 1'b0, 8'hFF};

  assign tx_bit = hold ? 1'b1 : word_q[idx_q];
  assign irq    = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      live_q <= 1'b0;
      irq_q  <= 1'b0;
      word_q <= FLAG_WORD;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (hold) begin
        idx_q <= '0;
      end else if (slot_stb) begin
        idx_q <= idx_q + 1'b1;
        if (last) begin
          if (pend_q) begin
            word_q <= next_word;
            live_q <= 1'b1;
            pend_q <= 1'b0;
            cnt_q  <= '0;
          end else if (!en_q) begin
            word_q <= FLAG_WORD;
            live_q <= 1'b0;
          end else if (live_q && cnt_q < CNT_W'(REPEATS)) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(REPEATS - 1)) irq_q <= 1'b1;
          end
        end
      end
      if (wr_en) begin
        msg_q  <= wr_msg;
        en_q   <= wr_enable;
        pend_q <= wr_enable;
        irq_q  <= 1'b0;
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(REPEATS));
  p_irq_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cnt_q == CNT_W'(REPEATS));
  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_en |=> irq);
  p_flag_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !hold && idx_q < IDX_W'(9) |-> tx_bit == (idx_q != IDX_W'(8)));
  p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq);
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_q));
endmodule

// File: tb/feac_tx_test.sv
module feac_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_msg = '0;
  logic wr_enable = 1'b0;
  logic slot_stb = 1'b0;
  logic ds3_mode = 1'b1;
  logic ais_active = 1'b0;
  logic tx_bit, irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  feac_tx #(.REPEATS(10)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_msg(wr_msg),
    .wr_enable(wr_enable), .slot_stb(slot_stb), .ds3_mode(ds3_mode),
    .ais_active(ais_active), .tx_bit(tx_bit), .irq(irq)
  );

  function automatic logic [15:0] cw(input logic [5:0] m);
    return {1'b0, m[2:0], m[5:3], 1'b0, 8'hFF};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(output logic b);
    @(negedge clk);
    b = tx_bit;
    slot_stb = 1'b1;
    @(negedge clk);
    slot_stb = 1'b0;
  endtask

  task automatic bits(input int n, output logic [15:0] w);
    logic b;
    w = '0;
    for (int i = 0; i < n; i++) begin
      strobe(b);
      w[i] = b;
    end
  endtask

  task automatic write(input logic [5:0] m, input logic en);
    @(negedge clk);
    wr_en = 1'b1; wr_msg = m; wr_enable = en;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ten(input logic [5:0] m, input string tag);
    logic [15:0] w;
    for (int r = 1; r <= 10; r++) begin
      bits(16, w);
      check({tag, " R2 R3 codeword"}, w, cw(m));
      if (r == 9) check("R4 no irq after nine", {15'd0, irq}, 16'd0);
      if (r == 10) check("R4 irq after ten", {15'd0, irq}, 16'd1);
    end
  endtask

  initial begin
    logic [15:0] w;
    logic b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset tx_bit", {15'd0, tx_bit}, 16'd1);
    check("R1 reset irq", {15'd0, irq}, 16'd0);
    bits(16, w);
    check("R1 idle flag", w, 16'hFFFF);

    write(6'd0, 1'b1);
    bits(16, w);
    check("R6 flag finishes first", w, 16'hFFFF);
    run_ten(6'd0, "msg0");

    for (int m = 1; m < 64; m++) begin
      bits(16, w);
      check("R7 repeats last", w, cw(6'(m - 1)));
      check("R5 irq held", {15'd0, irq}, 16'd1);
      write(6'(m), 1'b1);
      check("R5 write clears irq", {15'd0, irq}, 16'd0);
      bits(16, w);
      check("R6 old word finishes", w, cw(6'(m - 1)));
      run_ten(6'(m), "sweep");
    end

    bits(5, w);
    write(6'd21, 1'b1);
    begin
      logic [15:0] t;
      bits(11, t);
      w[15:5] = t[10:0];
    end
    check("R6 mid-word write keeps word", w, cw(6'd63));
    bits(16, w);
    check("R6 new word after boundary", w, cw(6'd21));

    bits(7, w);
    ais_active = 1'b1;
    for (int i = 0; i < 5; i++) begin
      strobe(b);
      check("R9 ais holds ones", {15'd0, b}, 16'd1);
    end
    ais_active = 1'b0;
    bits(16, w);
    check("R9 restart after ais", w, cw(6'd21));
    bits(3, w);
    ds3_mode = 1'b0;
    for (int i = 0; i < 4; i++) begin
      strobe(b);
      check("R9 non-ds3 holds ones", {15'd0, b}, 16'd1);
    end
    ds3_mode = 1'b1;
    for (int r = 3; r <= 10; r++) begin
      bits(16, w);
      check("R9 word after hold", w, cw(6'd21));
      if (r == 9) check("R9 R4 partial copies not counted", {15'd0, irq}, 16'd0);
      if (r == 10) check("R9 R4 irq after ten", {15'd0, irq}, 16'd1);
    end

    write(6'd5, 1'b0);
    check("R8 disable clears irq", {15'd0, irq}, 16'd0);
    bits(16, w);
    check("R8 current word finishes", w, cw(6'd21));
    for (int i = 0; i < 12; i++) begin
      bits(16, w);
      check("R8 idle ones", w, 16'hFFFF);
    end
    check("R8 no irq while disabled", {15'd0, irq}, 16'd0);

    write(6'd42, 1'b1);
    bits(16, w);
    check("R6 flag before reenable", w, 16'hFFFF);
    run_ten(6'd42, "reenable");
    done = 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
  end

  initial begin
    wait (done || $time > 64'd1199000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule